// File: doc/BRIEF.md
# PWM Carrier Chopper

This block takes one PWM waveform and chops it with a fast carrier, so that the signal can drive an isolating pulse transformer. The carrier is built from the system clock through a programmable divider, which sets the carrier clock. Each carrier period is split into eight carrier-clock phases. A duty code picks how many of those phases are high.

At each rising edge of the PWM input the block first sends out one solid pulse, whose width is a programmable number of carrier clocks. This wide pulse turns the power switch on quickly. After it, the output is the PWM input gated by the carrier. The divider and the carrier phase restart at every rising edge, so the chopped waveform always has the same timing relative to that edge. While the input is low the output is low. When the block is disabled (the reset default) the input passes through unchanged. In every mode the output is registered and comes one system clock after the input.

Top module: `pwm_chopper`

## Requirements
- R1: While reset is asserted and in the first cycle after it, chop_out is 0.
- R2: With en = 0, chop_out in each cycle equals the pwm_in value sampled at the previous clock edge.
- R3: With en = 1, a clock edge that samples pwm_in = 0 makes chop_out 0 for the following cycle.
- R4: With en = 1, the edge that first samples pwm_in = 1 after a low sample starts the one-shot. chop_out is then 1 for (pulse_code+1)*(div_code+1) cycles. The carrier clock is the system clock divided by div_code+1, with div_code 0..7 giving divide by 1..8.
- R5: After the one-shot, while pwm_in stays 1, chop_out steps through eight phases of div_code+1 cycles each, starting at phase 0 and repeating. It is 1 in phases p < duty_code. Codes 1..7 give 12.5% to 87.5%, and code 0 keeps the carrier low.
- R6: A fall of pwm_in cuts the one-shot short. Every new rising edge, even one only one low cycle after the last, restarts the one-shot and the carrier phase from the beginning.
- R7: The one-shot width covers 1 to 16 carrier clocks (pulse_code 0..15), and both extremes behave as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | 1 = chop, 0 = pass pwm_in through |
| pwm_in | input | 1 | PWM waveform to be chopped |
| div_code | input | 3 | Carrier clock divider minus one |
| pulse_code | input | 4 | One-shot width in carrier clocks minus one |
| duty_code | input | 3 | Number of high phases out of eight |
| chop_out | output | 1 | Chopped (or bypassed) output |

## Verification
The high bursts are tried with divider, one-shot and duty settings that include divide by 1 and by 8, one-shot widths of 1 and 16, and duty codes 0 and 7. Each output cycle is compared with a closed-form position-from-edge formula, so an error in the phase length, in where the one-shot ends or in the high-phase count each shows up at a different cycle. One burst is shorter than its one-shot and is followed after a single low cycle by a new burst, which separates a correct restart from a carried-over count. A toggling pattern in bypass mode checks that the output is the input delayed by one register.

// File: rtl/chop_pkg.sv
package chop_pkg;
    localparam int unsigned CHOP_PHASES = 8;
    localparam int unsigned PH_W        = $clog2(CHOP_PHASES);
endpackage

// File: rtl/chop_divider.sv
module chop_divider #(
    parameter int unsigned DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div_code,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt >= div_code);
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: the count never stays above the divider limit for more than one cycle
    a_r4_cnt_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt > div_code) |=> (st_q.cnt == '0));
endmodule

// File: rtl/chop_phase.sv
module chop_phase #(
    parameter int unsigned PH_W = chop_pkg::PH_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            adv,
    input  logic [PH_W-1:0] duty_code,
    output logic            level_next
);
    typedef struct packed {
        logic [PH_W-1:0] ph;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.ph = '0;
        end else if (adv) begin
            st_d.ph = st_q.ph + 1'b1;
        end
        level_next = (st_d.ph < duty_code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: an advance without restart moves exactly one phase on, wrapping after eight
    a_r5_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && adv) |=> (st_q.ph == PH_W'($past(st_q.ph) + 1'b1)));
endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper #(
    parameter int unsigned DIV_W  = 3,
    parameter int unsigned OSW_W  = 4,
    parameter int unsigned DUTY_W = chop_pkg::PH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              pwm_in,
    input  logic [DIV_W-1:0]  div_code,
    input  logic [OSW_W-1:0]  pulse_code,
    input  logic [DUTY_W-1:0] duty_code,
    output logic              chop_out
);
    typedef struct packed {
        logic             pwm;
        logic             os_act;
        logic [OSW_W-1:0] osc;
        logic             out;
    } top_state_t;

    top_state_t st_d, st_q;

    logic rise, tick, os_end, div_clr, ph_clr, ph_adv, car_lvl;

    assign rise    = pwm_in && !st_q.pwm;
    assign os_end  = en && pwm_in && !rise && st_q.os_act && tick
                     && (st_q.osc >= pulse_code);
    assign div_clr = !en || !pwm_in || rise;
    assign ph_clr  = !en || !pwm_in || rise || os_end;
    assign ph_adv  = tick && !st_q.os_act;

    chop_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (div_clr),
        .div_code (div_code),
        .tick     (tick)
    );

    chop_phase #(.PH_W(DUTY_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (ph_clr),
        .adv        (ph_adv),
        .duty_code  (duty_code),
        .level_next (car_lvl)
    );

    always_comb begin
        st_d     = st_q;
        st_d.pwm = pwm_in;
        if (!en) begin
            st_d.os_act = 1'b0;
            st_d.osc    = '0;
            st_d.out    = pwm_in;
        end else if (!pwm_in) begin
            st_d.os_act = 1'b0;
            st_d.osc    = '0;
            st_d.out    = 1'b0;
        end else if (rise) begin
            st_d.os_act = 1'b1;
            st_d.osc    = '0;
            st_d.out    = 1'b1;
        end else if (st_q.os_act) begin
            if (os_end) begin
                st_d.os_act = 1'b0;
                st_d.osc    = '0;
                st_d.out    = car_lvl;
            end else begin
                if (tick) begin
                    st_d.osc = st_q.osc + 1'b1;
                end
                st_d.out = 1'b1;
            end
        end else begin
            st_d.out = car_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chop_out = st_q.out;

    // R2: bypass is a one-register delay of the input
    a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (chop_out == $past(pwm_in)));

    // R3: a low input sample gives a low output
    a_r3_low_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !pwm_in) |=> !chop_out);

    // R4: the first high sample after a low one starts the one-shot high
    a_r4_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pwm_in && !st_q.pwm) |=> chop_out);

    // R7: the one-shot count stays within the programmed width
    a_r7_os_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(pulse_code) && st_q.os_act) |-> (st_q.osc <= pulse_code));
endmodule

// File: tb/pwm_chopper_bench.sv
module pwm_chopper_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       pwm_in = 1'b0;
    logic [2:0] div_code = '0;
    logic [3:0] pulse_code = '0;
    logic [2:0] duty_code = '0;
    logic       chop_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pwm_chopper u_pwm_chopper (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .pwm_in     (pwm_in),
        .div_code   (div_code),
        .pulse_code (pulse_code),
        .duty_code  (duty_code),
        .chop_out   (chop_out)
    );

    // {div_code, pulse_code, duty_code, high length}
    localparam int NV = 8;
    localparam logic [17:0] VEC [NV] = '{
        {3'd0, 4'd0,  3'd4, 8'd40},
        {3'd1, 4'd2,  3'd1, 8'd60},
        {3'd7, 4'd15, 3'd7, 8'd200},
        {3'd2, 4'd1,  3'd3, 8'd80},
        {3'd0, 4'd15, 3'd6, 8'd50},
        {3'd3, 4'd3,  3'd0, 8'd70},
        {3'd4, 4'd4,  3'd2, 8'd10},
        {3'd6, 4'd0,  3'd5, 8'd120}
    };

    function automatic logic exp_out(int t, int d, int w, int n);
        if (t < w * d) return 1'b1;
        return (((t - w * d) / d) % 8) < n;
    endfunction

    task automatic check(logic act, logic exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Drives a high burst (R4 R5 R6 R7), then one low cycle checked for R3
    task automatic run_burst(logic [2:0] dc, logic [3:0] wc, logic [2:0] nc,
                             int len, string req);
        int bad = 0;
        logic first_act = 1'b0;
        logic first_exp = 1'b0;
        @(negedge clk);
        div_code   = dc;
        pulse_code = wc;
        duty_code  = nc;
        pwm_in     = 1'b1;
        for (int t = 0; t < len; t++) begin
            logic e;
            @(negedge clk);
            e = exp_out(t, int'(dc) + 1, int'(wc) + 1, int'(nc));
            if (chop_out !== e && bad == 0) begin
                first_act = chop_out;
                first_exp = e;
            end
            if (chop_out !== e) bad++;
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s burst div=%0d pulse=%0d duty=%0d: %0d cycles wrong, first actual=%0b expected=%0b",
                     req, dc, wc, nc, bad, first_act, first_exp);
        end
        pwm_in = 1'b0;
        @(negedge clk);
        check(chop_out, 1'b0, "R3 low after burst");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(chop_out, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(chop_out, 1'b0, "R1 after reset");

        // R2: bypass with a toggling pattern
        begin
            logic [15:0] pat = 16'b1011_0011_1000_1101;
            int bad = 0;
            for (int i = 0; i < 16; i++) begin
                pwm_in = pat[i];
                @(negedge clk);
                if (chop_out !== pat[i]) bad++;
            end
            checks++;
            if (bad != 0) begin
                errors++;
                $display("FAIL R2 bypass: %0d cycles wrong, actual=%0b expected=%0b",
                         bad, chop_out, pat[15]);
            end
        end
        pwm_in = 1'b0;
        @(negedge clk);
        check(chop_out, 1'b0, "R2 bypass low");

        en = 1'b1;
        @(negedge clk);
        check(chop_out, 1'b0, "R3 enabled idle");

        // Table walk: entry 6 is cut short (R6) and entry 7 restarts after one low cycle
        for (int v = 0; v < NV; v++) begin
            run_burst(VEC[v][17:15], VEC[v][14:11], VEC[v][10:8], int'(VEC[v][7:0]),
                      (v == 6 || v == 7) ? "R6 cut/restart" :
                      (v == 2 || v == 4) ? "R7 width extreme" : "R4/R5 chop");
        end

        // R6: short bursts back to back, each restarts the one-shot
        run_burst(3'd1, 4'd3, 3'd4, 5, "R6 short burst");
        run_burst(3'd1, 4'd3, 3'd4, 30, "R6 restart after short");
        // R7: narrowest one-shot with divide by one and full duty code
        run_burst(3'd0, 4'd0, 3'd7, 24, "R7 one-clock pulse");

        // R2: disabling mid-stream passes the input straight through
        en = 1'b0;
        pwm_in = 1'b1;
        @(negedge clk);
        check(chop_out, 1'b1, "R2 bypass high");
        @(negedge clk);
        check(chop_out, 1'b1, "R2 bypass held high");
        pwm_in = 1'b0;
        @(negedge clk);
        check(chop_out, 1'b0, "R2 bypass fall");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule